// File: doc/BRIEF.md
# Lockable Cache Way Replacement Selector

This block chooses which way of a four-way set-associative cache receives a line fill. The caller supplies the six-bit pairwise age code of the set being filled, a DSP-mode flag and a prefetch flag. The block holds a small control register with lock and load bits for ways 2 and 3. It returns a two-bit victim way index in the same cycle, combinationally.

A locked way is kept out of normal replacement. The victim is then the oldest way among the ways that remain free. The load bit of a locked way steers DSP-mode prefetches into that way, so software can stream prefetched data into a reserved region of the cache. If the age code does not describe a consistent ordering of the four ways, the block falls back to way 0 and raises a flag.

Top module: `cway_victim_sel`

## Requirements
- R1: Control register layout: bit 0 is the way-2 lock, bit 1 the way-2 load, bit 8 the way-3 lock and bit 9 the way-3 load. A write with `ctl_wr_en` high is captured on that rising edge. It is visible on `ctl_rd_data` and acts on the decode from then on, and not before.
- R2: Every `ctl_rd_data` bit other than 0, 1, 8 and 9 always reads zero, whatever value was written.
- R3: An active-low `rst_n` clears the whole control register to zero.
- R4: Age code meaning: bit 5 orders ways 0/1, bit 4 ways 0/2, bit 3 ways 0/3, bit 2 ways 1/2, bit 1 ways 1/3 and bit 0 ways 2/3. A 1 means the lower-numbered way of the pair is older. With no lock set and a consistent code, the victim is the way older than all three others.
- R5: With only the way-2 lock set, the victim is the oldest of ways 0, 1 and 3. Way 2 is never chosen unless R8 applies.
- R6: With only the way-3 lock set, the victim is the oldest of ways 0, 1 and 2. Way 3 is never chosen unless R9 applies.
- R7: With both locks set, the victim is way 0 when age bit 5 is 1 and way 1 when it is 0.
- R8: A fill with `dsp_mode` and `is_prefetch` high, while the way-2 lock and load bits are both set, selects way 2.
- R9: A fill with `dsp_mode` and `is_prefetch` high, while the way-3 lock and load bits are both set, selects way 3. This holds only if R8 does not apply.
- R10: When both steering conditions hold at once, way 2 wins.
- R11: Steering needs all four conditions: lock, load, DSP mode and prefetch. A load bit alone, or a fill that is not a DSP-mode prefetch, uses the age decode.
- R12: A code that does not describe a consistent ordering of the four ways raises `illegal_code` in every mode. When no steering applies, such a code yields way 0. `illegal_code` is low for every consistent code.
- R13: `victim_way` and `illegal_code` follow their inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 16 | Control register write value |
| ctl_rd_data | output | 16 | Control register contents, unused bits zero |
| lru_code | input | 6 | Pairwise age code of the set being filled |
| dsp_mode | input | 1 | Processor is in DSP mode |
| is_prefetch | input | 1 | The fill comes from a prefetch |
| victim_way | output | 2 | Way index chosen for the fill |
| illegal_code | output | 1 | Age code is not a consistent ordering |

## Verification
Some properties are checked by assertion on every cycle:
- a write reaches the register one edge later, with its unused bits cleared;
- no locked way is ever picked without steering;
- every steering case and its priority;
- a flagged code leads to way 0 when no steering applies.

Other properties only the bench scenarios can show:
- the exact way each lock mode picks for given codes, including codes whose answer changes when a way is locked;
- that write data stays hidden until the edge after the strobe;
- that a reset in the middle of a run clears the register;
- that the output follows an input change with no clock edge.

// File: rtl/cway_pkg.sv
package cway_pkg;
    localparam int WAYS  = 4;
    localparam int AGE_W = WAYS * (WAYS - 1) / 2;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAY_W-1:0] way_t;

    typedef struct packed {
        logic load3;
        logic lock3;
        logic load2;
        logic lock2;
    } ctl_t;
endpackage

// File: rtl/cway_ctl_reg.sv
module cway_ctl_reg
    import cway_pkg::*;
#(
    parameter int CTL_W   = 16,
    parameter int LK2_POS = 0,
    parameter int LD2_POS = 1,
    parameter int LK3_POS = 8,
    parameter int LD3_POS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl,
    output logic [CTL_W-1:0] rd_data
);
    ctl_t ctl_d, ctl_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.lock2 = wr_data[LK2_POS];
            ctl_d.load2 = wr_data[LD2_POS];
            ctl_d.lock3 = wr_data[LK3_POS];
            ctl_d.load3 = wr_data[LD3_POS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data          = '0;
        rd_data[LK2_POS] = ctl_q.lock2;
        rd_data[LD2_POS] = ctl_q.load2;
        rd_data[LK3_POS] = ctl_q.lock3;
        rd_data[LD3_POS] = ctl_q.load3;
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/cway_age_rank.sv
module cway_age_rank
    import cway_pkg::*;
(
    input  logic [AGE_W-1:0]            lru_code,
    output logic [WAYS-1:0][WAY_W-1:0]  older_cnt,
    output logic                        legal
);
    // Pairs in order (0,1),(0,2),(0,3),(1,2),(1,3),(2,3) map to code bits
    // from the top down; a set bit credits the lower way of the pair.
    always_comb begin
        int k;
        k = 0;
        older_cnt = '0;
        for (int a = 0; a < WAYS; a++) begin
            for (int b = a + 1; b < WAYS; b++) begin
                if (lru_code[AGE_W-1-k]) older_cnt[a] = older_cnt[a] + 1'b1;
                else                     older_cnt[b] = older_cnt[b] + 1'b1;
                k = k + 1;
            end
        end
    end

    // A consistent ordering gives every way a distinct count.
    always_comb begin
        legal = 1'b1;
        for (int a = 0; a < WAYS; a++)
            for (int b = a + 1; b < WAYS; b++)
                if (older_cnt[a] == older_cnt[b]) legal = 1'b0;
    end
endmodule

// File: rtl/cway_pick.sv
module cway_pick
    import cway_pkg::*;
(
    input  logic [WAYS-1:0][WAY_W-1:0] older_cnt,
    input  logic                       legal,
    input  logic [WAYS-1:0]            locked,
    input  logic                       steer2,
    input  logic                       steer3,
    output way_t                       victim
);
    way_t       best_way;
    logic [WAY_W-1:0] best_cnt;
    logic       found;

    always_comb begin
        best_way = '0;
        best_cnt = '0;
        found    = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!locked[w] && (!found || older_cnt[w] > best_cnt)) begin
                best_way = way_t'(w);
                best_cnt = older_cnt[w];
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        if (steer2)      victim = way_t'(2);
        else if (steer3) victim = way_t'(3);
        else if (!legal) victim = '0;
        else             victim = best_way;
    end
endmodule

// File: rtl/cway_victim_sel.sv
module cway_victim_sel
    import cway_pkg::*;
#(
    parameter int CTL_W   = 16,
    parameter int LK2_POS = 0,
    parameter int LD2_POS = 1,
    parameter int LK3_POS = 8,
    parameter int LD3_POS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    output logic [CTL_W-1:0] ctl_rd_data,
    input  logic [AGE_W-1:0] lru_code,
    input  logic             dsp_mode,
    input  logic             is_prefetch,
    output logic [WAY_W-1:0] victim_way,
    output logic             illegal_code
);
    ctl_t                       ctl;
    logic [WAYS-1:0][WAY_W-1:0] older_cnt;
    logic                       legal;
    logic [WAYS-1:0]            locked;
    logic                       dsp_pf, steer2, steer3;

    cway_ctl_reg #(
        .CTL_W(CTL_W), .LK2_POS(LK2_POS), .LD2_POS(LD2_POS),
        .LK3_POS(LK3_POS), .LD3_POS(LD3_POS)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .ctl(ctl), .rd_data(ctl_rd_data)
    );

    cway_age_rank u_rank (
        .lru_code(lru_code), .older_cnt(older_cnt), .legal(legal)
    );

    assign locked = {ctl.lock3, ctl.lock2, 2'b00};
    assign dsp_pf = dsp_mode & is_prefetch;
    assign steer2 = dsp_pf & ctl.lock2 & ctl.load2;
    assign steer3 = dsp_pf & ctl.lock3 & ctl.load3;

    cway_pick u_pick (
        .older_cnt(older_cnt), .legal(legal), .locked(locked),
        .steer2(steer2), .steer3(steer3), .victim(victim_way)
    );

    assign illegal_code = ~legal;
endmodule

// File: rtl/cway_victim_chk.sv
module cway_victim_chk #(
    parameter int CTL_W   = 16,
    parameter int LK2_POS = 0,
    parameter int LD2_POS = 1,
    parameter int LK3_POS = 8,
    parameter int LD3_POS = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr_en,
    input logic [CTL_W-1:0] ctl_wr_data,
    input logic [CTL_W-1:0] ctl_rd_data,
    input logic             dsp_mode,
    input logic             is_prefetch,
    input logic [1:0]       victim_way,
    input logic             illegal_code
);
    logic [CTL_W-1:0] keep_mask;
    logic lk2, ld2, lk3, ld3, pf_dsp;

    always_comb begin
        keep_mask          = '0;
        keep_mask[LK2_POS] = 1'b1;
        keep_mask[LD2_POS] = 1'b1;
        keep_mask[LK3_POS] = 1'b1;
        keep_mask[LD3_POS] = 1'b1;
    end

    assign lk2    = ctl_rd_data[LK2_POS];
    assign ld2    = ctl_rd_data[LD2_POS];
    assign lk3    = ctl_rd_data[LK3_POS];
    assign ld3    = ctl_rd_data[LD3_POS];
    assign pf_dsp = dsp_mode & is_prefetch;

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> ctl_rd_data == ($past(ctl_wr_data) & keep_mask));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_data & ~keep_mask) == '0);

    assert_lock2_protected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk2 && !(pf_dsp && ld2)) |-> victim_way != 2'd2);

    assert_lock3_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk3 && !(pf_dsp && (ld3 || (lk2 && ld2)))) |-> victim_way != 2'd3);

    assert_steer_way2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_dsp && lk2 && ld2) |-> victim_way == 2'd2);

    assert_steer_way3_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_dsp && lk3 && ld3 && !(lk2 && ld2)) |-> victim_way == 2'd3);

    assert_illegal_way0_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_code && !(pf_dsp && ((lk2 && ld2) || (lk3 && ld3))))
            |-> victim_way == 2'd0);
endmodule

bind cway_victim_sel cway_victim_chk #(
    .CTL_W(CTL_W), .LK2_POS(LK2_POS), .LD2_POS(LD2_POS),
    .LK3_POS(LK3_POS), .LD3_POS(LD3_POS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .dsp_mode(dsp_mode), .is_prefetch(is_prefetch),
    .victim_way(victim_way), .illegal_code(illegal_code)
);

// File: tb/test_cway_victim_sel.sv
module test_cway_victim_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [15:0] ctl_wr_data = '0;
    logic [15:0] ctl_rd_data;
    logic [5:0]  lru_code = '0;
    logic        dsp_mode = 1'b0;
    logic        is_prefetch = 1'b0;
    logic [1:0]  victim_way;
    logic        illegal_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cway_victim_sel i_cway_victim_sel (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .lru_code(lru_code), .dsp_mode(dsp_mode),
        .is_prefetch(is_prefetch), .victim_way(victim_way), .illegal_code(illegal_code)
    );

    // Vector: [15:12] {load3,lock3,load2,lock2}, [11] dsp, [10] prefetch,
    //         [9:4] age code, [3:2] expected way, [1] expected flag, [0] unused
    localparam int NV = 22;
    localparam logic [15:0] VEC [NV] = '{
        {4'b0000, 1'b0, 1'b0, 6'b000000, 2'd3, 1'b0, 1'b0},  // R4
        {4'b0000, 1'b0, 1'b0, 6'b111000, 2'd0, 1'b0, 1'b0},  // R4
        {4'b0000, 1'b0, 1'b0, 6'b000111, 2'd1, 1'b0, 1'b0},  // R4
        {4'b0000, 1'b0, 1'b0, 6'b000001, 2'd2, 1'b0, 1'b0},  // R4
        {4'b0000, 1'b0, 1'b0, 6'b001001, 2'd0, 1'b1, 1'b0},  // R12
        {4'b0001, 1'b0, 1'b0, 6'b000100, 2'd3, 1'b0, 1'b0},  // R5
        {4'b0001, 1'b0, 1'b0, 6'b000011, 2'd1, 1'b0, 1'b0},  // R5
        {4'b0001, 1'b0, 1'b0, 6'b101001, 2'd0, 1'b0, 1'b0},  // R5
        {4'b0001, 1'b0, 1'b0, 6'b000001, 2'd3, 1'b0, 1'b0},  // R5
        {4'b0100, 1'b0, 1'b0, 6'b000000, 2'd2, 1'b0, 1'b0},  // R6
        {4'b0100, 1'b0, 1'b0, 6'b000100, 2'd1, 1'b0, 1'b0},  // R6
        {4'b0100, 1'b0, 1'b0, 6'b110000, 2'd0, 1'b0, 1'b0},  // R6
        {4'b0101, 1'b0, 1'b0, 6'b000000, 2'd1, 1'b0, 1'b0},  // R7
        {4'b0101, 1'b0, 1'b0, 6'b100000, 2'd0, 1'b0, 1'b0},  // R7
        {4'b0011, 1'b1, 1'b1, 6'b000000, 2'd2, 1'b0, 1'b0},  // R8
        {4'b1100, 1'b1, 1'b1, 6'b111000, 2'd3, 1'b0, 1'b0},  // R9
        {4'b0011, 1'b1, 1'b0, 6'b000000, 2'd3, 1'b0, 1'b0},  // R11
        {4'b0011, 1'b0, 1'b1, 6'b000011, 2'd1, 1'b0, 1'b0},  // R11
        {4'b0010, 1'b1, 1'b1, 6'b000000, 2'd3, 1'b0, 1'b0},  // R11
        {4'b1111, 1'b1, 1'b1, 6'b000000, 2'd2, 1'b0, 1'b0},  // R10
        {4'b0011, 1'b1, 1'b1, 6'b001001, 2'd2, 1'b1, 1'b0},  // R12
        {4'b0001, 1'b0, 1'b0, 6'b001001, 2'd0, 1'b1, 1'b0}   // R12
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [15:0] val);
        @(negedge clk);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = val;
        @(negedge clk);
        ctl_wr_en   = 1'b0;
    endtask

    function automatic logic [15:0] ctl_word(input logic [3:0] n);
        logic [15:0] v;
        v    = '0;
        v[0] = n[0];
        v[1] = n[1];
        v[8] = n[2];
        v[9] = n[3];
        return v;
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(ctl_rd_data == 16'h0, "R3 reset value", ctl_rd_data, 0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            write_ctl(ctl_word(v[15:12]));
            dsp_mode    = v[11];
            is_prefetch = v[10];
            lru_code    = v[9:4];
            #1;
            check(victim_way == v[3:2], $sformatf("R4-R12 vec %0d way", i), victim_way, v[3:2]);
            check(illegal_code == v[1], $sformatf("R12 vec %0d flag", i), illegal_code, v[1]);
        end
        dsp_mode = 1'b0;
        is_prefetch = 1'b0;

        // R2: unused bits stay zero
        write_ctl(16'hFFFF);
        #1;
        check(ctl_rd_data == 16'h0303, "R2 reserved bits", ctl_rd_data, 16'h0303);

        // R1: data hidden until the strobe edge
        write_ctl(16'h0000);
        lru_code = 6'b000001;
        @(negedge clk);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = 16'h0001;
        #1;
        check(ctl_rd_data == 16'h0, "R1 before edge", ctl_rd_data, 0);
        check(victim_way == 2'd2, "R1 decode before edge", victim_way, 2);
        @(negedge clk);
        ctl_wr_en = 1'b0;
        #1;
        check(ctl_rd_data == 16'h0001, "R1 after edge", ctl_rd_data, 1);
        check(victim_way == 2'd3, "R1 decode after edge", victim_way, 3);

        // R13: combinational response with no edge
        @(posedge clk);
        #1;
        lru_code = 6'b000011;
        #0.5;
        check(victim_way == 2'd1, "R13 same cycle", victim_way, 1);

        // R3: reset mid-run clears the register
        write_ctl(16'h0303);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(ctl_rd_data == 16'h0, "R3 mid-run reset", ctl_rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: every consistent code is unflagged, counted by brute force
        begin
            int flagged;
            flagged = 0;
            for (int c = 0; c < 64; c++) begin
                lru_code = c[5:0];
                #1;
                if (illegal_code) flagged++;
            end
            check(flagged == 40, "R12 flagged count", flagged, 40);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule